// File: doc/BRIEF.md
# Pin-Change and External Interrupt Front End

This block turns pin activity into interrupt requests for a small controller. Six general-purpose pins are watched through a per-pin enable mask. Whenever an enabled pin changes level, in either direction, a sticky pin-change flag is raised. Each pin passes through a capture stage, a synchronizer stage and a history stage. A toggle is seen when the synchronized copy differs from the history copy.

A seventh, dedicated pin feeds an external interrupt. Its sense control selects one of four triggers: low level, any change, falling edge or rising edge. The edge triggers need the clock and set a sticky flag. The low-level trigger is purely combinational. A wake-up output gathers every request. It also gathers an unclocked comparison of the raw enabled pins against their last sampled values, so the sleep logic can be woken while the clock is stopped. The block never looks at pin direction, so driving a pin from inside the chip can raise a software interrupt.

Top module: `pin_irq_front`

## Requirements
- R1: A change on pin `pinIn[i]` can set the pin-change flag only when `pcMask[i]` is 1; with `pcMask[i]` at 0 the change leaves `pcIrq` low.
- R2: A change applied to `pinIn` before rising edge k, with `clkRun` high, shows on `pcIrq` after edge k+2 and not after edge k+1. Rising and falling changes both count.
- R3: After reset is released, the first running clock edge loads every history stage from the current pin values. No flag is raised by reset alone, whatever the pin levels are.
- R4: With `pcIntEn` at 1, `wakeReq` rises combinationally when any enabled pin differs from its last sampled value. This holds even while `clkRun` is 0. A masked pin does not cause it. A change held while the clock is halted is flagged two edges after the clock resumes.
- R5: With `senseCtl` = 00 (low level), `extIrq` equals `extIntEn AND NOT extPin` combinationally. It stays high as long as the pin is low, and it drives `wakeReq` without the clock.
- R6: `senseCtl` = 01 flags any change of `extPin`, 10 flags a falling edge and 11 flags a rising edge. The flag appears on `extIrq` after edge k+2 for a change applied before edge k.
- R7: While `clkRun` is 0 the pipelines and flags are frozen. A pulse on `pinIn` or `extPin` that starts and ends while the clock is halted raises no flag.
- R8: Both flags are sticky until their clear strobe (`pcFlagClr`, `extFlagClr`) is sampled at an edge with `clkRun` at 1. If a set and a clear land on the same edge, the flag ends up set. A clear sampled while `clkRun` is 0 is ignored.
- R9: `pcIrq` is the pin-change flag gated by `pcIntEn`. `extIrq` is the edge flag plus the level request, gated by `extIntEn`. Dropping an enable hides the flag without clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkRun | input | 1 | High while the I/O clock is running; low freezes all state |
| pinIn | input | 6 | Raw general-purpose pin levels |
| pcMask | input | 6 | Per-pin enable for pin-change detection |
| pcIntEn | input | 1 | Pin-change interrupt enable |
| pcFlagClr | input | 1 | One-cycle clear strobe for the pin-change flag |
| extPin | input | 1 | Raw level of the dedicated external interrupt pin |
| senseCtl | input | 2 | 00 low level, 01 any change, 10 falling, 11 rising |
| extIntEn | input | 1 | External interrupt enable |
| extFlagClr | input | 1 | One-cycle clear strobe for the external edge flag |
| pcIrq | output | 1 | Pin-change interrupt request |
| extIrq | output | 1 | External interrupt request |
| wakeReq | output | 1 | Wake-up request, valid with or without the clock |

## Verification
A flag can be set and cleared on the same edge. The bench provokes this by raising a clear strobe exactly one cycle before a detected toggle or edge reaches its flag. The expected result is that the flag is still high afterwards. The same pair of actions is then split over separate edges to confirm that the clear does work on its own. The other overlap is a freeze falling together with pin activity: toggles are applied and withdrawn while the clock is halted, and the bench checks that the combinational wake path responds while the clocked flags stay silent.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;   // shift pipelines, allow flag set
    logic prime;     // load every stage from the raw pins
    logic armed;     // history valid for the unclocked compare
    logic pcClr;     // clear pin-change flag
    logic extClr;    // clear external edge flag
  } pipeCtl_t;

endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     clkRun,
  input  logic     pcFlagClr,
  input  logic     extFlagClr,
  output pipeCtl_t ctl
);

  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       primed <= 1'b0;
    else if (clkRun) primed <= 1'b1;
  end

  always_comb begin
    ctl.advance = clkRun & primed;
    ctl.prime   = clkRun & ~primed;
    ctl.armed   = primed;
    ctl.pcClr   = clkRun & primed & pcFlagClr;
    ctl.extClr  = clkRun & primed & extFlagClr;
  end

endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  pipeCtl_t            ctl,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pcMask,
  input  logic                pcIntEn,
  input  logic                extPin,
  input  logic [1:0]          senseCtl,
  input  logic                extIntEn,
  output logic                pcIrq,
  output logic                extIrq,
  output logic                wakeReq
);

  logic [NUM_PINS-1:0] pcDiff;     // synchronized vs history, masked
  logic [NUM_PINS-1:0] pcRawDiff;  // raw pin vs history, masked

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic latQ, syncQ, prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latQ  <= 1'b0;
        syncQ <= 1'b0;
        prevQ <= 1'b0;
      end else if (ctl.prime) begin
        latQ  <= pinIn[i];
        syncQ <= pinIn[i];
        prevQ <= pinIn[i];
      end else if (ctl.advance) begin
        latQ  <= pinIn[i];
        syncQ <= latQ;
        prevQ <= syncQ;
      end
    end

    assign pcDiff[i]    = pcMask[i] & (syncQ ^ prevQ);
    assign pcRawDiff[i] = pcMask[i] & (pinIn[i] ^ prevQ);
  end

  // External pin pipeline
  logic extLat, extSync, extPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extLat  <= 1'b0;
      extSync <= 1'b0;
      extPrev <= 1'b0;
    end else if (ctl.prime) begin
      extLat  <= extPin;
      extSync <= extPin;
      extPrev <= extPin;
    end else if (ctl.advance) begin
      extLat  <= extPin;
      extSync <= extLat;
      extPrev <= extSync;
    end
  end

  senseMode_e senseMode;
  logic       extRise, extFall, extHit, levelReq;

  assign senseMode = senseMode_e'(senseCtl);
  assign extRise   = extSync & ~extPrev;
  assign extFall   = ~extSync & extPrev;

  always_comb begin
    unique case (senseMode)
      SENSE_ANY:  extHit = extRise | extFall;
      SENSE_FALL: extHit = extFall;
      SENSE_RISE: extHit = extRise;
      default:    extHit = 1'b0;
    endcase
  end

  assign levelReq = (senseMode == SENSE_LOW) & ~extPin;

  // Sticky flags: set has priority over clear
  logic pcFlag, extFlag, pcSet, extSet;

  assign pcSet  = ctl.advance & (|pcDiff);
  assign extSet = ctl.advance & extHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcFlag  <= 1'b0;
      extFlag <= 1'b0;
    end else begin
      if (pcSet)           pcFlag  <= 1'b1;
      else if (ctl.pcClr)  pcFlag  <= 1'b0;
      if (extSet)          extFlag <= 1'b1;
      else if (ctl.extClr) extFlag <= 1'b0;
    end
  end

  assign pcIrq   = pcFlag & pcIntEn;
  assign extIrq  = extIntEn & (extFlag | levelReq);
  assign wakeReq = pcIrq | extIrq | (pcIntEn & ctl.armed & (|pcRawDiff));

endmodule

// File: rtl/pin_irq_front.sv
module pin_irq_front
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkRun,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pcMask,
  input  logic                pcIntEn,
  input  logic                pcFlagClr,
  input  logic                extPin,
  input  logic [1:0]          senseCtl,
  input  logic                extIntEn,
  input  logic                extFlagClr,
  output logic                pcIrq,
  output logic                extIrq,
  output logic                wakeReq
);

  pipeCtl_t ctl;

  pin_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkRun     (clkRun),
    .pcFlagClr  (pcFlagClr),
    .extFlagClr (extFlagClr),
    .ctl        (ctl)
  );

  pin_irq_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .pinIn    (pinIn),
    .pcMask   (pcMask),
    .pcIntEn  (pcIntEn),
    .extPin   (extPin),
    .senseCtl (senseCtl),
    .extIntEn (extIntEn),
    .pcIrq    (pcIrq),
    .extIrq   (extIrq),
    .wakeReq  (wakeReq)
  );

endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       clkRun,
  input logic       pcIntEn,
  input logic       pcFlagClr,
  input logic       extPin,
  input logic [1:0] senseCtl,
  input logic       extIntEn,
  input logic       extFlagClr,
  input logic       pcIrq,
  input logic       extIrq
);

  a_r5_level_request: assert property (@(posedge clk) disable iff (!rstN)
    (extIntEn && senseCtl == 2'b00 && !extPin) |-> extIrq);

  a_r7_pc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!clkRun && pcIntEn && !pcIrq) |=> !pcIrq);

  a_r7_ext_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!clkRun && extIntEn && senseCtl != 2'b00 && !extIrq) |=> (!extIrq || senseCtl == 2'b00));

  a_r8_pc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pcIrq && pcIntEn && !pcFlagClr) |=> (pcIrq || !pcIntEn));

  a_r8_ext_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (extIrq && senseCtl != 2'b00 && extIntEn && !extFlagClr) |=> (extIrq || !extIntEn));

endmodule

bind pin_irq_front pin_irq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkRun     (clkRun),
  .pcIntEn    (pcIntEn),
  .pcFlagClr  (pcFlagClr),
  .extPin     (extPin),
  .senseCtl   (senseCtl),
  .extIntEn   (extIntEn),
  .extFlagClr (extFlagClr),
  .pcIrq      (pcIrq),
  .extIrq     (extIrq)
);

// File: tb/pin_irq_front_bench.sv
module pin_irq_front_bench;

  logic       clk = 1'b0;
  logic       rstN, clkRun, pcIntEn, pcFlagClr, extPin, extIntEn, extFlagClr;
  logic [5:0] pinIn, pcMask;
  logic [1:0] senseCtl;
  logic       pcIrq, extIrq, wakeReq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pin_irq_front u_pin_irq_front (
    .clk(clk), .rstN(rstN), .clkRun(clkRun), .pinIn(pinIn), .pcMask(pcMask),
    .pcIntEn(pcIntEn), .pcFlagClr(pcFlagClr), .extPin(extPin), .senseCtl(senseCtl),
    .extIntEn(extIntEn), .extFlagClr(extFlagClr), .pcIrq(pcIrq), .extIrq(extIrq),
    .wakeReq(wakeReq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearPc();
    pcFlagClr = 1'b1; step(1); pcFlagClr = 1'b0; step(1);
  endtask

  task automatic clearExt();
    extFlagClr = 1'b1; step(1); extFlagClr = 1'b0; step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clkRun = 1'b1; pinIn = 6'b101010; pcMask = 6'h3F;
    pcIntEn = 1'b1; pcFlagClr = 1'b0; extPin = 1'b1; senseCtl = 2'b10;
    extIntEn = 1'b1; extFlagClr = 1'b0;
    step(3);
    rstN = 1'b1;
    step(5);
    chk("R3 pc after reset", pcIrq, 1'b0);
    chk("R3 ext after reset", extIrq, 1'b0);
    chk("R3 wake after reset", wakeReq, 1'b0);

    // R1 / R2: every pin under every mask, alternating directions
    for (int p = 0; p < 6; p++) begin
      for (int m = 0; m < 64; m++) begin
        pcMask = m[5:0];
        clearPc();
        pinIn[p] = ~pinIn[p];
        step(2);
        chk("R2 not before edge k+2", pcIrq, 1'b0);
        step(1);
        chk("R1 mask gating", pcIrq, m[p]);
      end
    end

    // R4 / R7: clock halted
    pcMask = 6'h01;
    clearPc();
    clkRun = 1'b0;
    pinIn[0] = ~pinIn[0];
    #1 chk("R4 wake while halted", wakeReq, 1'b1);
    chk("R7 no flag while halted", pcIrq, 1'b0);
    step(2);
    chk("R7 still no flag", pcIrq, 1'b0);
    pinIn[0] = ~pinIn[0];
    #1 chk("R4 wake drops on return", wakeReq, 1'b0);
    clkRun = 1'b1;
    step(4);
    chk("R7 halted pulse ignored", pcIrq, 1'b0);
    clkRun = 1'b0;
    pinIn[0] = ~pinIn[0];
    step(2);
    clkRun = 1'b1;
    step(3);
    chk("R4 held change flagged on resume", pcIrq, 1'b1);
    clearPc();
    pcMask = 6'h00;
    clkRun = 1'b0;
    pinIn[1] = ~pinIn[1];
    #1 chk("R4 masked pin no wake", wakeReq, 1'b0);
    pinIn[1] = ~pinIn[1];
    clkRun = 1'b1;
    step(4);

    // R8: set and clear on the same edge, stickiness, clear alone
    pcMask = 6'h3F;
    clearPc();
    pinIn[2] = ~pinIn[2];
    step(2);
    pcFlagClr = 1'b1;
    step(1);
    pcFlagClr = 1'b0;
    chk("R8 set wins over clear", pcIrq, 1'b1);
    step(5);
    chk("R8 flag sticky", pcIrq, 1'b1);
    clkRun = 1'b0;
    clearPc();
    clkRun = 1'b1;
    chk("R8 clear ignored while halted", pcIrq, 1'b1);
    clearPc();
    chk("R8 clear alone", pcIrq, 1'b0);

    // R9: enable hides but keeps the flag
    pinIn[3] = ~pinIn[3];
    step(3);
    pcIntEn = 1'b0;
    #1 chk("R9 pc enable off", pcIrq, 1'b0);
    pcIntEn = 1'b1;
    #1 chk("R9 pc flag retained", pcIrq, 1'b1);
    step(1);
    clearPc();

    // R6: edge modes on the dedicated pin
    for (int md = 1; md < 4; md++) begin
      senseCtl = md[1:0];
      extPin = 1'b1;
      step(4);
      clearExt();
      extPin = 1'b0;
      step(2);
      chk("R6 not before edge k+2", extIrq, 1'b0);
      step(1);
      chk("R6 falling", extIrq, (md == 1) || (md == 2));
      clearExt();
      chk("R8 ext clear", extIrq, 1'b0);
      extPin = 1'b1;
      step(3);
      chk("R6 rising", extIrq, (md == 1) || (md == 3));
      clearExt();
    end

    // R5: low level
    senseCtl = 2'b00;
    extPin = 1'b1;
    step(2);
    chk("R5 high pin no request", extIrq, 1'b0);
    extPin = 1'b0;
    #1 chk("R5 low level request", extIrq, 1'b1);
    clkRun = 1'b0;
    #1 chk("R5 wake without clock", wakeReq, 1'b1);
    extIntEn = 1'b0;
    #1 chk("R9 ext enable off", extIrq, 1'b0);
    extIntEn = 1'b1;
    extPin = 1'b1;
    #1 chk("R5 release drops request", extIrq, 1'b0);
    clkRun = 1'b1;
    step(2);

    // R7: external edge while halted
    senseCtl = 2'b10;
    step(4);
    clearExt();
    clkRun = 1'b0;
    extPin = 1'b0;
    step(2);
    extPin = 1'b1;
    step(1);
    clkRun = 1'b1;
    step(4);
    chk("R7 ext edge ignored while halted", extIrq, 1'b0);

    // R8: ext set wins
    extPin = 1'b0;
    step(2);
    extFlagClr = 1'b1;
    step(1);
    extFlagClr = 1'b0;
    chk("R8 ext set wins over clear", extIrq, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule